// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Sequencer

This block carries out a single two-operand addition of the form `Rd <- Rd + operand`. The second operand comes from one of five addressing modes. It can be another register or a signed constant held in the instruction. It can also come from memory: at the address in a source register, at that address plus a signed displacement, or through a pointer fetched from memory. The register file sits outside the block. The sequencer drives two read addresses, samples the values returned, and issues one write port when the result is ready.

Memory is reached through a read-request channel with a valid/ready handshake and a separate read-data-valid return. The sequencer makes as many dependent reads as the mode calls for. A read that accepts a request never overlaps another one. A caller pulses `start_i` with an instruction word and then waits for `done_i` or `illegal_o`. Starts that arrive while an instruction is in flight are dropped.

Top module: `opfetch_seq`

## Requirements
- R1: Mode code 0 (register): the destination register is written with its old value plus the source register, and no memory read is issued; this holds when both fields name the same register, and the 32-bit sum wraps.
- R2: Mode code 1 (immediate): the destination is written with its old value plus bits [15:0] of the instruction sign-extended to 32 bits, with no memory read.
- R3: Mode code 2 (register indirect): exactly one memory read is made at the address held in the source register, and the returned word is added to the destination.
- R4: Mode code 3 (displacement): exactly one memory read is made at the source register plus sign-extended bits [15:0], and the returned word is added to the destination.
- R5: Mode code 4 (memory indirect): a first read at the source register value returns a pointer, and a second read at that pointer returns the operand that is added; exactly two reads are made.
- R6: Mode codes 5, 6 and 7 raise `illegal_o` for exactly one cycle, make no memory read, and cause no register write.
- R7: `done_o` is high for exactly one cycle, in the same cycle as `rf_we_o`, and `rf_waddr_o` carries the destination field.
- R8: A memory request holds `mem_req_valid_o` and an unchanged address until `mem_req_ready_i` is seen. The sequencer then waits for `mem_rvalid_i` before its next step.
- R9: A `start_i` pulse that arrives while an instruction is in progress is ignored. It causes no additional write, and the result of the running instruction is unchanged.
- R10: While reset is held, `done_o`, `illegal_o`, `rf_we_o` and `mem_req_valid_o` are low.
- R11: For register and immediate modes, `done_o` is high in the second cycle after the clock edge that captures `start_i` (one decode cycle, then the writeback cycle).
- R12: The instruction word places the mode in bits [31:29], the destination index in [28:26], the source index in [25:23], and the constant in [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begins an instruction when the sequencer is idle |
| instr_i | input | 32 | Instruction word, captured with `start_i` |
| done_o | output | 1 | One-cycle completion pulse, coincident with the write |
| illegal_o | output | 1 | One-cycle pulse for an unsupported mode code |
| rf_raddr_d_o | output | 3 | Register file read index for the destination |
| rf_raddr_s_o | output | 3 | Register file read index for the source |
| rf_rdata_d_i | input | 32 | Destination register value |
| rf_rdata_s_i | input | 32 | Source register value |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench targets the memory-indirect chain and checks that the second read goes to the data returned by the first. A design that reused the source address, or summed the pointer itself, would write the wrong value or make a read at the wrong address. It runs negative displacements and immediates with the top bit set, where a missing sign extension moves the address or the sum by 64 K. It also runs a destination equal to the source and a sum that wraps past 32 bits. Further tests check that a start pulse arriving during a stalled fetch does not produce a second write. They also check that illegal mode codes leave both the memory port and the register file untouched, and that requests stay stable under varied ready and response delays.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int NUM_REGS = 8;
  localparam int REG_AW  = $clog2(NUM_REGS);
  localparam int IMM_W   = 16;
  localparam int MODE_W  = 3;
  localparam int INSTR_W = 32;

  // addressing mode codes (R12 places them in the top bits of the word)
  localparam logic [MODE_W-1:0] AM_REG  = 3'd0;
  localparam logic [MODE_W-1:0] AM_IMM  = 3'd1;
  localparam logic [MODE_W-1:0] AM_RIND = 3'd2;
  localparam logic [MODE_W-1:0] AM_DISP = 3'd3;
  localparam logic [MODE_W-1:0] AM_MIND = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_REQ1   = 3'd2,
    ST_WAIT1  = 3'd3,
    ST_REQ2   = 3'd4,
    ST_WAIT2  = 3'd5,
    ST_WB     = 3'd6,
    ST_BAD    = 3'd7
  } seq_state_e;

endpackage

// File: rtl/opfetch_reset_sync.sv
module opfetch_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/opfetch_decode.sv
module opfetch_decode
  import opfetch_pkg::*;
#(
  parameter int IW  = INSTR_W,
  parameter int MW  = MODE_W,
  parameter int RW  = REG_AW,
  parameter int KW  = IMM_W,
  parameter int DW  = DATA_W
) (
  input  logic [IW-1:0] instr_i,
  output logic [RW-1:0] dst_idx_o,
  output logic [RW-1:0] src_idx_o,
  output logic [DW-1:0] konst_o,
  output logic          use_reg_o,
  output logic          use_imm_o,
  output logic          use_mem_o,
  output logic          use_disp_o,
  output logic          use_chain_o,
  output logic          bad_mode_o
);

  localparam int MODE_LSB = IW - MW;
  localparam int DST_LSB  = MODE_LSB - RW;
  localparam int SRC_LSB  = DST_LSB - RW;

  logic [MW-1:0] mode;
  logic [KW-1:0] konst_raw;
  logic          unused_gap;

  assign mode      = instr_i[MODE_LSB +: MW];
  assign dst_idx_o = instr_i[DST_LSB +: RW];
  assign src_idx_o = instr_i[SRC_LSB +: RW];
  assign konst_raw = instr_i[KW-1:0];
  assign unused_gap = ^instr_i[SRC_LSB-1:KW];

  if (DW > KW) begin : g_sext
    assign konst_o = {{(DW-KW){konst_raw[KW-1]}}, konst_raw};
  end else begin : g_trunc
    assign konst_o = konst_raw[DW-1:0];
  end

  always_comb begin
    use_reg_o   = (mode == AM_REG);
    use_imm_o   = (mode == AM_IMM);
    use_disp_o  = (mode == AM_DISP);
    use_chain_o = (mode == AM_MIND);
    use_mem_o   = (mode == AM_RIND) || (mode == AM_DISP) || (mode == AM_MIND);
    bad_mode_o  = !(use_reg_o || use_imm_o || use_mem_o);
  end

endmodule

// File: rtl/opfetch_agu.sv
module opfetch_agu #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] offset_i,
  input  logic          use_offset_i,
  output logic [AW-1:0] addr_o
);

  logic [DW-1:0] sum;

  always_comb begin
    sum    = base_i + (use_offset_i ? offset_i : '0);
    addr_o = AW'(sum);
  end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int RW = REG_AW,
  parameter int IW = INSTR_W,
  parameter int KW = IMM_W,
  parameter int RST_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] instr_i,
  output logic          done_o,
  output logic          illegal_o,
  output logic [RW-1:0] rf_raddr_d_o,
  output logic [RW-1:0] rf_raddr_s_o,
  input  logic [DW-1:0] rf_rdata_d_i,
  input  logic [DW-1:0] rf_rdata_s_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);

  logic       rst_n_s;
  seq_state_e state_q, state_d;

  logic [IW-1:0] instr_q;
  logic          instr_en;
  logic [DW-1:0] dest_q;
  logic          dest_en;
  logic [DW-1:0] opnd_q, opnd_d;
  logic          opnd_en;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  logic [RW-1:0] dst_idx, src_idx;
  logic [DW-1:0] konst;
  logic          use_reg, use_imm, use_mem, use_disp, use_chain, bad_mode;
  logic [AW-1:0] eff_addr;

  opfetch_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  opfetch_decode #(.IW(IW), .MW(MODE_W), .RW(RW), .KW(KW), .DW(DW)) u_dec (
    .instr_i     (instr_q),
    .dst_idx_o   (dst_idx),
    .src_idx_o   (src_idx),
    .konst_o     (konst),
    .use_reg_o   (use_reg),
    .use_imm_o   (use_imm),
    .use_mem_o   (use_mem),
    .use_disp_o  (use_disp),
    .use_chain_o (use_chain),
    .bad_mode_o  (bad_mode)
  );

  opfetch_agu #(.DW(DW), .AW(AW)) u_agu (
    .base_i       (rf_rdata_s_i),
    .offset_i     (konst),
    .use_offset_i (use_disp),
    .addr_o       (eff_addr)
  );

  // next-state and datapath enables
  always_comb begin
    state_d  = state_q;
    instr_en = 1'b0;
    dest_en  = 1'b0;
    opnd_en  = 1'b0;
    opnd_d   = opnd_q;
    addr_en  = 1'b0;
    addr_d   = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          instr_en = 1'b1;
          state_d  = ST_DECODE;
        end
      end
      ST_DECODE: begin
        dest_en = 1'b1;
        if (bad_mode) begin
          state_d = ST_BAD;
        end else if (use_reg) begin
          opnd_en = 1'b1;
          opnd_d  = rf_rdata_s_i;
          state_d = ST_WB;
        end else if (use_imm) begin
          opnd_en = 1'b1;
          opnd_d  = konst;
          state_d = ST_WB;
        end else if (use_mem) begin
          addr_en = 1'b1;
          addr_d  = eff_addr;
          state_d = ST_REQ1;
        end
      end
      ST_REQ1: begin
        if (mem_req_ready_i) state_d = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (mem_rvalid_i) begin
          if (use_chain) begin
            addr_en = 1'b1;
            addr_d  = AW'(mem_rdata_i);
            state_d = ST_REQ2;
          end else begin
            opnd_en = 1'b1;
            opnd_d  = mem_rdata_i;
            state_d = ST_WB;
          end
        end
      end
      ST_REQ2: begin
        if (mem_req_ready_i) state_d = ST_WAIT2;
      end
      ST_WAIT2: begin
        if (mem_rvalid_i) begin
          opnd_en = 1'b1;
          opnd_d  = mem_rdata_i;
          state_d = ST_WB;
        end
      end
      ST_WB:   state_d = ST_IDLE;
      ST_BAD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk_i) begin
    if (instr_en) instr_q <= instr_i;
  end

  always_ff @(posedge clk_i) begin
    if (dest_en) dest_q <= rf_rdata_d_i;
  end

  always_ff @(posedge clk_i) begin
    if (opnd_en) opnd_q <= opnd_d;
  end

  always_ff @(posedge clk_i) begin
    if (addr_en) addr_q <= addr_d;
  end

  assign rf_raddr_d_o    = dst_idx;
  assign rf_raddr_s_o    = src_idx;
  assign done_o          = (state_q == ST_WB);
  assign rf_we_o         = (state_q == ST_WB);
  assign rf_waddr_o      = dst_idx;
  assign rf_wdata_o      = dest_q + opnd_q;
  assign illegal_o       = (state_q == ST_BAD);
  assign mem_req_valid_o = (state_q == ST_REQ1) || (state_q == ST_REQ2);
  assign mem_req_addr_o  = addr_q;

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          done,
  input logic          illegal,
  input logic          rf_we,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr
);

  // R8: request stays up with a stable address until accepted
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R7: completion pulse lasts one cycle
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    done |=> !done);

  // R7: no completion while a request is outstanding on the port
  p_done_not_req_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_valid |-> !done);

  // R6: illegal pulse is one cycle and is not followed by a write
  p_bad_single_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal |=> (!illegal && !rf_we));

  // R6: illegal cycle carries no write and no request
  p_bad_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal |-> (!rf_we && !mem_valid));

endmodule

bind opfetch_seq opfetch_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_s),
  .done      (done_o),
  .illegal   (illegal_o),
  .rf_we     (rf_we_o),
  .mem_valid (mem_req_valid_o),
  .mem_ready (mem_req_ready_i),
  .mem_addr  (mem_req_addr_o)
);

// File: tb/opfetch_seq_bench.sv
module opfetch_seq_bench;

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  rd;
    logic [2:0]  rs;
    logic [15:0] imm;
    logic [3:0]  rdy;
    logic [3:0]  rsp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd1, 3'd2, 16'h0000, 4'd0, 4'd0},
    '{3'd0, 3'd3, 3'd3, 16'h0000, 4'd0, 4'd0},
    '{3'd0, 3'd7, 3'd1, 16'h0000, 4'd0, 4'd0},
    '{3'd1, 3'd2, 3'd0, 16'h0005, 4'd0, 4'd0},
    '{3'd1, 3'd4, 3'd0, 16'hFFFF, 4'd0, 4'd0},
    '{3'd1, 3'd5, 3'd0, 16'h8000, 4'd0, 4'd0},
    '{3'd2, 3'd1, 3'd3, 16'h0000, 4'd0, 4'd0},
    '{3'd2, 3'd6, 3'd2, 16'h0000, 4'd3, 4'd2},
    '{3'd3, 3'd2, 3'd4, 16'h0010, 4'd1, 4'd1},
    '{3'd3, 3'd3, 3'd5, 16'hFFF0, 4'd0, 4'd3},
    '{3'd4, 3'd4, 3'd6, 16'h0000, 4'd0, 4'd0},
    '{3'd4, 3'd0, 3'd7, 16'h0000, 4'd2, 4'd4},
    '{3'd5, 3'd1, 3'd2, 16'h0000, 4'd0, 4'd0},
    '{3'd7, 3'd3, 3'd4, 16'h0000, 4'd0, 4'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [31:0] instr_i;
  logic        done_o, illegal_o;
  logic [2:0]  rf_raddr_d_o, rf_raddr_s_o, rf_waddr_o;
  logic [31:0] rf_rdata_d_i, rf_rdata_s_i, rf_wdata_o;
  logic        rf_we_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [31:0] mem_req_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  opfetch_seq u_opfetch_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .instr_i         (instr_i),
    .done_o          (done_o),
    .illegal_o       (illegal_o),
    .rf_raddr_d_o    (rf_raddr_d_o),
    .rf_raddr_s_o    (rf_raddr_s_o),
    .rf_rdata_d_i    (rf_rdata_d_i),
    .rf_rdata_s_i    (rf_rdata_s_i),
    .rf_we_o         (rf_we_o),
    .rf_waddr_o      (rf_waddr_o),
    .rf_wdata_o      (rf_wdata_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rvalid_i    (mem_rvalid_i),
    .mem_rdata_i     (mem_rdata_i)
  );

  // ---------------- models ----------------
  function automatic logic [31:0] rinit(input int i);
    return (i == 7) ? 32'hFFFF_FFF0 : 32'h0100_0040 * (i + 1);
  endfunction

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h00A5_5A00;
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] k);
    return {{16{k[15]}}, k};
  endfunction

  logic [31:0] regs [8];
  logic        do_init;
  assign rf_rdata_d_i = regs[rf_raddr_d_o];
  assign rf_rdata_s_i = regs[rf_raddr_s_o];

  always @(posedge clk_i) begin
    if (do_init) begin
      for (int i = 0; i < 8; i++) regs[i] <= rinit(i);
    end else if (rf_we_o) begin
      regs[rf_waddr_o] <= rf_wdata_o;
    end
  end

  int          rdy_lat, rsp_lat;
  int          stall, pend;
  logic [31:0] pend_data;
  int          nreads;
  logic [31:0] addr_log [2];
  logic        clr_reads;
  int          wecount;
  int          hold_viol;
  logic        prev_valid, prev_ready;
  logic [31:0] prev_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_ready_i <= 1'b0;
      mem_rvalid_i    <= 1'b0;
      mem_rdata_i     <= '0;
      stall <= 0;
      pend  <= -1;
      nreads <= 0;
      wecount <= 0;
      hold_viol <= 0;
      prev_valid <= 1'b0;
      prev_ready <= 1'b0;
      prev_addr  <= '0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (pend == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= pend_data;
        pend <= -1;
      end else if (pend > 0) begin
        pend <= pend - 1;
      end
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (nreads < 2) addr_log[nreads] <= mem_req_addr_o;
        nreads <= clr_reads ? 1 : nreads + 1;
        mem_req_ready_i <= 1'b0;
        pend      <= rsp_lat;
        pend_data <= memf(mem_req_addr_o);
        stall     <= 0;
      end else begin
        if (clr_reads) nreads <= 0;
        if (mem_req_valid_o) begin
          if (stall >= rdy_lat) mem_req_ready_i <= 1'b1;
          else                  stall <= stall + 1;
        end
      end
      if (rf_we_o) wecount <= wecount + 1;
      // R8: observed at the ports
      if (prev_valid && !prev_ready && (!mem_req_valid_o || mem_req_addr_o != prev_addr))
        hold_viol <= hold_viol + 1;
      prev_valid <= mem_req_valid_o;
      prev_ready <= mem_req_ready_i;
      prev_addr  <= mem_req_addr_o;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] m, input logic [2:0] d,
                                      input logic [2:0] s, input logic [15:0] k);
    return {m, d, s, 7'd0, k};
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic prep(input int rl, input int pl);
    @(negedge clk_i);
    do_init = 1'b1;
    clr_reads = 1'b1;
    rdy_lat = rl;
    rsp_lat = pl;
    @(negedge clk_i);
    do_init = 1'b0;
    clr_reads = 1'b0;
  endtask

  task automatic wait_end(output int cyc);
    cyc = 1;
    while (!(done_o || illegal_o) && cyc < 300) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] dv, sv, expv;
    int cyc, we0, exp_reads;
    prep(int'(v.rdy), int'(v.rsp));
    dv = regs[v.rd];
    sv = regs[v.rs];
    we0 = wecount;
    start_i = 1'b1;
    instr_i = mk(v.mode, v.rd, v.rs, v.imm);
    @(negedge clk_i);
    start_i = 1'b0;
    wait_end(cyc);
    case (v.mode)
      3'd0: expv = dv + sv;
      3'd1: expv = dv + sx(v.imm);
      3'd2: expv = dv + memf(sv);
      3'd3: expv = dv + memf(sv + sx(v.imm));
      default: expv = dv + memf(memf(sv));
    endcase
    exp_reads = (v.mode == 3'd2 || v.mode == 3'd3) ? 1 : (v.mode == 3'd4) ? 2 : 0;
    if (v.mode <= 3'd4) begin
      check(done_o && rf_we_o, {tag(v.mode), " R7 done with write"}, {30'd0, done_o, rf_we_o}, 32'd3);
      check(rf_waddr_o == v.rd, {tag(v.mode), " R7 write index"}, 32'(rf_waddr_o), 32'(v.rd));
      check(rf_wdata_o == expv, {tag(v.mode), " sum"}, rf_wdata_o, expv);
      check(nreads == exp_reads, {tag(v.mode), " read count"}, 32'(nreads), 32'(exp_reads));
      if (v.mode <= 3'd1)
        check(cyc == 2, {tag(v.mode), " R11 latency"}, 32'(cyc), 32'd2);
      if (v.mode == 3'd2 || v.mode == 3'd4)
        check(addr_log[0] == sv, {tag(v.mode), " first address"}, addr_log[0], sv);
      if (v.mode == 3'd3)
        check(addr_log[0] == sv + sx(v.imm), "R4 displaced address", addr_log[0], sv + sx(v.imm));
      if (v.mode == 3'd4)
        check(addr_log[1] == memf(sv), "R5 pointer address", addr_log[1], memf(sv));
      @(negedge clk_i);
      check(!done_o && !rf_we_o, "R7 one-cycle done", {31'd0, done_o}, 32'd0);
    end else begin
      check(illegal_o && !rf_we_o, "R6 illegal pulse", {30'd0, illegal_o, rf_we_o}, 32'd2);
      @(negedge clk_i);
      check(!illegal_o, "R6 one-cycle illegal", {31'd0, illegal_o}, 32'd0);
      repeat (4) @(negedge clk_i);
      check(wecount == we0, "R6 no write", 32'(wecount), 32'(we0));
      check(nreads == 0, "R6 no read", 32'(nreads), 32'd0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int cyc, we0;
    logic [31:0] dv, sv;
    rst_ni = 1'b0;
    start_i = 1'b0;
    instr_i = '0;
    do_init = 1'b0;
    clr_reads = 1'b0;
    rdy_lat = 0;
    rsp_lat = 0;
    repeat (4) @(negedge clk_i);
    // R10
    check(!done_o && !illegal_o && !rf_we_o && !mem_req_valid_o, "R10 reset outputs",
          {28'd0, done_o, illegal_o, rf_we_o, mem_req_valid_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(!done_o && !mem_req_valid_o, "R10 idle after reset",
          {30'd0, done_o, mem_req_valid_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: start during a stalled memory-indirect fetch
    prep(5, 3);
    dv = regs[2];
    sv = regs[6];
    we0 = wecount;
    start_i = 1'b1;
    instr_i = mk(3'd4, 3'd2, 3'd6, 16'h0);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    start_i = 1'b1;
    instr_i = mk(3'd0, 3'd5, 3'd5, 16'h0);
    @(negedge clk_i);
    start_i = 1'b0;
    wait_end(cyc);
    check(done_o && rf_waddr_o == 3'd2, "R9 first instruction finishes", 32'(rf_waddr_o), 32'd2);
    check(rf_wdata_o == dv + memf(memf(sv)), "R9 result unchanged", rf_wdata_o, dv + memf(memf(sv)));
    repeat (10) @(negedge clk_i);
    check(wecount == we0 + 1, "R9 single write", 32'(wecount), 32'(we0 + 1));
    check(hold_viol == 0, "R8 request hold", 32'(hold_viol), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule